// File: doc/BRIEF.md
# Local Interrupt Priority and Acceptance Unit

This unit sits beside one processor core and decides which interrupt the core should take next. It keeps three bit arrays indexed by vector number: pending requests, vectors in service, and the trigger mode (level or edge) of each request. A task-priority value and a spurious-vector configuration complete its state. Incoming trigger pulses carry a vector and its trigger mode; the unit raises an interrupt line to the core when the best pending vector outranks both the vector in service and the task priority.

The core answers with an acknowledge pulse and receives a vector one cycle later: either the winning request, which moves from pending to in-service, or the programmed spurious vector when nothing pending is allowed through. An end-of-interrupt write retires the highest vector in service, and for a level-triggered vector it emits a one-cycle broadcast pulse naming that vector so the originating source can re-sample its line. The current processor priority is driven out continuously.

All inputs are single-cycle pulses with a valid qualifier and no ready: the unit accepts every trigger, acknowledge, end-of-interrupt and configuration write in the cycle it is presented, so no back-pressure exists in either direction. The acknowledge response and the broadcast pulse are each valid for exactly one cycle and cannot be stalled.

Top module: `lapic_prio_unit`

## Requirements
- R1: A trigger whose vector is below 0x10 or equal to 0xFF changes no pending, in-service or trigger-mode state and sets `err_illegal_vec`, which stays at 1 until reset.
- R2: A legal trigger for a vector that is already pending is dropped, including its trigger mode; with `trig_extint` = 1 it is taken anyway and overwrites the recorded trigger mode. Otherwise the trigger marks the vector pending and records `trig_level` (1 = level).
- R3: `core_irq` rises (on the second clock edge after the trigger) only when the highest pending vector is strictly greater than the highest in-service vector (or none is in service) and its class (bits 7:4) is greater than the task-priority class; once high it stays high until an acknowledge.
- R4: `proc_prio` equals the task priority when nothing is in service or when task-priority bits 7:4 are at least the class of the highest in-service vector; otherwise it equals that in-service vector with bits 3:0 cleared.
- R5: One cycle after `ack_req`, `ack_valid` is 1 for one cycle and `ack_vector` carries the highest pending vector, which moves to in-service, unless nothing is pending or that vector's class with low nibble zero is not above `proc_prio`, in which case it carries the spurious vector and no state moves. `core_irq` is 0 in the cycle after the acknowledge edge and is re-evaluated on the next edge.
- R6: An end-of-interrupt write clears the highest in-service vector; if that vector was recorded as level it clears the mode bit and, one cycle later, pulses `eoi_bcast_valid` with `eoi_bcast_vector` equal to it. Edge vectors produce no pulse.
- R7: An end-of-interrupt write has no effect when nothing is in service or when the highest in-service vector equals the spurious vector.
- R8: `spur_cfg` reads bit 9 as the stored focus-disable bit, bit 8 as the stored software-enable bit, bits 7:4 as the written vector bits and bits 3:0 always as 1; the spurious vector returned is bits 7:0 of that value.
- R9: Lowering the task priority so that a pending vector now qualifies raises `core_irq` by the second edge after the write.
- R10: After reset nothing is pending or in service, the task priority and `proc_prio` are 0, `core_irq`, `ack_valid`, `eoi_bcast_valid` and `err_illegal_vec` are 0, and `spur_cfg` reads 0x0FF.
- R11: With several vectors pending, successive acknowledge and end-of-interrupt pairs return them in descending vector order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger pulse |
| trig_vector | input | 8 | Vector of the trigger |
| trig_level | input | 1 | Trigger mode, 1 = level |
| trig_extint | input | 1 | External-interrupt delivery, skips the already-pending check |
| ack_req | input | 1 | Acknowledge pulse from the core |
| eoi_write | input | 1 | End-of-interrupt write pulse |
| tpr_write | input | 1 | Task-priority write strobe |
| tpr_data | input | 8 | Task-priority write value |
| spur_write | input | 1 | Spurious-configuration write strobe |
| spur_data | input | 10 | Spurious-configuration write value |
| core_irq | output | 1 | Interrupt request to the core |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Acknowledged or spurious vector |
| eoi_bcast_valid | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector of the broadcast |
| proc_prio | output | 8 | Current processor priority |
| spur_cfg | output | 10 | Spurious configuration readback |
| err_illegal_vec | output | 1 | Sticky illegal-vector error |

## Verification
The bench builds the unit with its default parameters: 8-bit vectors, 4-bit classes and a legal window of 0x10 to 0xFE. At that size every one of the 256 vectors is swept, in both edge and level mode, through trigger, acknowledge and end-of-interrupt, so the window edges, the class boundaries and the broadcast rule are all reached. Directed sequences then cover same-class acceptance where the acknowledge turns spurious, task-priority masking and release, duplicate and external-interrupt triggers, and an end-of-interrupt aimed at the spurious vector.

// File: rtl/lapic_pkg.sv
package lapic_pkg;
  localparam int DEF_VEC_W  = 8;
  localparam int DEF_CLS_W  = 4;
  localparam int DEF_VEC_LO = 16;
  localparam int DEF_VEC_HI = 254;
endpackage

// File: rtl/lapic_prio_enc.sv
module lapic_prio_enc #(
  parameter int N  = 256,
  parameter int LO = 16,
  parameter int HI = 254,
  parameter int IW = 8
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic edge_unused;
  assign edge_unused = ^{bits[LO-1:0], bits[N-1:HI+1]};

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LO; i <= HI; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lapic_prio_eval.sv
module lapic_prio_eval #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic             req_found,
  input  logic [VEC_W-1:0] req_idx,
  input  logic             svc_found,
  input  logic [VEC_W-1:0] svc_idx,
  input  logic [VEC_W-1:0] task_prio,
  output logic [VEC_W-1:0] proc_prio,
  output logic             accept,
  output logic             take
);
  localparam int SUB_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] req_cls, svc_cls, tp_cls;
  logic [VEC_W-1:0] req_floor;

  assign req_cls   = req_idx[VEC_W-1:SUB_W];
  assign svc_cls   = svc_idx[VEC_W-1:SUB_W];
  assign tp_cls    = task_prio[VEC_W-1:SUB_W];
  assign req_floor = {req_cls, {SUB_W{1'b0}}};

  always_comb begin
    if (!svc_found || tp_cls >= svc_cls) proc_prio = task_prio;
    else                                 proc_prio = {svc_cls, {SUB_W{1'b0}}};
  end

  assign accept = req_found && (!svc_found || req_idx > svc_idx) && (req_cls > tp_cls);
  assign take   = req_found && (req_floor > proc_prio);
endmodule

// File: rtl/lapic_prio_unit.sv
module lapic_prio_unit
  import lapic_pkg::*;
#(
  parameter int VEC_W  = DEF_VEC_W,
  parameter int CLS_W  = DEF_CLS_W,
  parameter int VEC_LO = DEF_VEC_LO,
  parameter int VEC_HI = DEF_VEC_HI
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [VEC_W-1:0]   trig_vector,
  input  logic               trig_level,
  input  logic               trig_extint,
  input  logic               ack_req,
  input  logic               eoi_write,
  input  logic               tpr_write,
  input  logic [VEC_W-1:0]   tpr_data,
  input  logic               spur_write,
  input  logic [VEC_W+1:0]   spur_data,
  output logic               core_irq,
  output logic               ack_valid,
  output logic [VEC_W-1:0]   ack_vector,
  output logic               eoi_bcast_valid,
  output logic [VEC_W-1:0]   eoi_bcast_vector,
  output logic [VEC_W-1:0]   proc_prio,
  output logic [VEC_W+1:0]   spur_cfg,
  output logic               err_illegal_vec
);
  localparam int NV    = 1 << VEC_W;
  localparam int SUB_W = VEC_W - CLS_W;
  localparam int CFG_W = VEC_W + 2;
  localparam int STO_W = CFG_W - SUB_W;

  logic [NV-1:0]    req_q, svc_q, lvl_q;
  logic [NV-1:0]    req_n, svc_n, lvl_n;
  logic [VEC_W-1:0] task_prio_q;
  logic [STO_W-1:0] spur_q;
  logic             irq_q, ackv_q, bcv_q, err_q;
  logic [VEC_W-1:0] ackvec_q, bcvec_q;

  logic             req_found, svc_found, accept, take, legal, bc_fire;
  logic [VEC_W-1:0] req_idx, svc_idx, spur_vec;
  logic             spur_low_unused;

  assign spur_low_unused = ^spur_data[SUB_W-1:0];
  assign spur_vec = {spur_q[CLS_W-1:0], {SUB_W{1'b1}}};
  assign legal    = (trig_vector >= VEC_W'(VEC_LO)) && (trig_vector <= VEC_W'(VEC_HI));

  lapic_prio_enc #(.N(NV), .LO(VEC_LO), .HI(VEC_HI), .IW(VEC_W)) u_req_enc (
    .bits(req_q), .found(req_found), .idx(req_idx)
  );

  lapic_prio_enc #(.N(NV), .LO(VEC_LO), .HI(VEC_HI), .IW(VEC_W)) u_svc_enc (
    .bits(svc_q), .found(svc_found), .idx(svc_idx)
  );

  lapic_prio_eval #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_eval (
    .req_found(req_found), .req_idx(req_idx),
    .svc_found(svc_found), .svc_idx(svc_idx),
    .task_prio(task_prio_q), .proc_prio(proc_prio),
    .accept(accept), .take(take)
  );

  always_comb begin
    req_n   = req_q;
    svc_n   = svc_q;
    lvl_n   = lvl_q;
    bc_fire = 1'b0;
    if (ack_req && take) begin
      req_n[req_idx] = 1'b0;
      svc_n[req_idx] = 1'b1;
    end
    if (eoi_write && svc_found && (svc_idx != spur_vec)) begin
      svc_n[svc_idx] = 1'b0;
      if (lvl_q[svc_idx]) begin
        lvl_n[svc_idx] = 1'b0;
        bc_fire        = 1'b1;
      end
    end
    if (trig_valid && legal && (!req_q[trig_vector] || trig_extint)) begin
      req_n[trig_vector] = 1'b1;
      lvl_n[trig_vector] = trig_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q       <= '0;
      svc_q       <= '0;
      lvl_q       <= '0;
      task_prio_q <= '0;
      spur_q      <= {2'b00, {CLS_W{1'b1}}};
      irq_q       <= 1'b0;
      ackv_q      <= 1'b0;
      ackvec_q    <= '0;
      bcv_q       <= 1'b0;
      bcvec_q     <= '0;
      err_q       <= 1'b0;
    end else begin
      req_q  <= req_n;
      svc_q  <= svc_n;
      lvl_q  <= lvl_n;
      if (tpr_write)  task_prio_q <= tpr_data;
      if (spur_write) spur_q      <= spur_data[CFG_W-1:SUB_W];
      irq_q    <= ack_req ? 1'b0 : (irq_q | accept);
      ackv_q   <= ack_req;
      if (ack_req) ackvec_q <= take ? req_idx : spur_vec;
      bcv_q    <= bc_fire;
      if (bc_fire) bcvec_q <= svc_idx;
      err_q    <= err_q | (trig_valid & ~legal);
    end
  end

  assign core_irq         = irq_q;
  assign ack_valid        = ackv_q;
  assign ack_vector       = ackvec_q;
  assign eoi_bcast_valid  = bcv_q;
  assign eoi_bcast_vector = bcvec_q;
  assign spur_cfg         = {spur_q, {SUB_W{1'b1}}};
  assign err_illegal_vec  = err_q;
endmodule

// File: rtl/lapic_prio_chk.sv
module lapic_prio_chk #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_req,
  input logic             ack_valid,
  input logic [VEC_W-1:0] ack_vector,
  input logic             core_irq,
  input logic [VEC_W-1:0] proc_prio,
  input logic [VEC_W-1:0] task_prio,
  input logic [VEC_W-1:0] spur_vec,
  input logic             eoi_write,
  input logic             eoi_bcast_valid,
  input logic             err_illegal_vec,
  input logic             req_found
);
  localparam int SUB_W = VEC_W - CLS_W;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal_vec |=> err_illegal_vec); // R1

  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_irq) |-> $past(req_found)); // R3

  AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    proc_prio >= task_prio); // R4

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !core_irq); // R5

  AST_ACK_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ((ack_vector == $past(spur_vec)) ||
                   ((ack_vector >> SUB_W) > ($past(proc_prio) >> SUB_W)))); // R5

  AST_BCAST_FROM_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> $past(eoi_write)); // R6
endmodule

bind lapic_prio_unit lapic_prio_chk #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_valid(ack_valid),
  .ack_vector(ack_vector), .core_irq(core_irq), .proc_prio(proc_prio),
  .task_prio(task_prio_q), .spur_vec(spur_vec), .eoi_write(eoi_write),
  .eoi_bcast_valid(eoi_bcast_valid), .err_illegal_vec(err_illegal_vec),
  .req_found(req_found)
);

// File: tb/lapic_prio_unit_test.sv
`timescale 1ns/1ps
module lapic_prio_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_valid = 1'b0, trig_level = 1'b0, trig_extint = 1'b0;
  logic [7:0] trig_vector = '0;
  logic       ack_req = 1'b0, eoi_write = 1'b0, tpr_write = 1'b0, spur_write = 1'b0;
  logic [7:0] tpr_data = '0;
  logic [9:0] spur_data = '0;
  logic       core_irq, ack_valid, eoi_bcast_valid, err_illegal_vec;
  logic [7:0] ack_vector, eoi_bcast_vector, proc_prio;
  logic [9:0] spur_cfg;

  int total = 0, bad = 0;
  logic [7:0] g_vec;
  logic       g_vld, g_irq_mid, g_bcv;
  logic [7:0] g_bcvec;

  always #4 clk = ~clk;

  lapic_prio_unit uut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_vector(trig_vector),
    .trig_level(trig_level), .trig_extint(trig_extint), .ack_req(ack_req),
    .eoi_write(eoi_write), .tpr_write(tpr_write), .tpr_data(tpr_data),
    .spur_write(spur_write), .spur_data(spur_data), .core_irq(core_irq),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .eoi_bcast_valid(eoi_bcast_valid),
    .eoi_bcast_vector(eoi_bcast_vector), .proc_prio(proc_prio), .spur_cfg(spur_cfg),
    .err_illegal_vec(err_illegal_vec)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic trig(input logic [7:0] v, input logic lvl, input logic ext);
    trig_valid = 1'b1; trig_vector = v; trig_level = lvl; trig_extint = ext;
    @(negedge clk);
    trig_valid = 1'b0; trig_extint = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    ack_req = 1'b1;
    @(negedge clk);
    g_vec = ack_vector; g_vld = ack_valid; g_irq_mid = core_irq;
    ack_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic eoi();
    eoi_write = 1'b1;
    @(negedge clk);
    eoi_write = 1'b0;
    g_bcv = eoi_bcast_valid; g_bcvec = eoi_bcast_vector;
    @(negedge clk);
  endtask

  task automatic set_tpr(input logic [7:0] d);
    tpr_write = 1'b1; tpr_data = d;
    @(negedge clk);
    tpr_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_spur(input logic [9:0] d);
    spur_write = 1'b1; spur_data = d;
    @(negedge clk);
    spur_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack_expect(input logic [7:0] e, input string tag);
    ack();
    chk(g_vld === 1'b1, tag, g_vld, 1);
    chk(g_vec === e, tag, g_vec, e);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk(core_irq === 1'b0, "R10 irq", core_irq, 0);
    chk(ack_valid === 1'b0, "R10 ack_valid", ack_valid, 0);
    chk(eoi_bcast_valid === 1'b0, "R10 bcast", eoi_bcast_valid, 0);
    chk(proc_prio === 8'h00, "R10 ppr", proc_prio, 0);
    chk(spur_cfg === 10'h0FF, "R10 spur", spur_cfg, 10'h0FF);
    chk(err_illegal_vec === 1'b0, "R10 err", err_illegal_vec, 0);

    // full vector sweep: R1, R3, R4, R5, R6
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vv;
      vv = 8'(v);
      if (v < 16 || v == 255) begin
        do_reset();
        trig(vv, 1'b0, 1'b0);
        chk(core_irq === 1'b0, "R1 irq", core_irq, 0);
        chk(err_illegal_vec === 1'b1, "R1 err", err_illegal_vec, 1);
        ack_expect(8'hFF, "R1 ack spurious");
        chk(proc_prio === 8'h00, "R1 ppr", proc_prio, 0);
      end else begin
        trig(vv, 1'b0, 1'b0);
        chk(core_irq === 1'b1, "R3 irq", core_irq, 1);
        ack_expect(vv, "R5 ack vector");
        chk(g_irq_mid === 1'b0, "R5 irq drop", g_irq_mid, 0);
        chk(proc_prio === {vv[7:4], 4'h0}, "R4 ppr svc", proc_prio, {vv[7:4], 4'h0});
        eoi();
        chk(g_bcv === 1'b0, "R6 edge no bcast", g_bcv, 0);
        chk(proc_prio === 8'h00, "R6 ppr after eoi", proc_prio, 0);
        trig(vv, 1'b1, 1'b0);
        ack_expect(vv, "R5 ack level");
        eoi();
        chk(g_bcv === 1'b1, "R6 bcast valid", g_bcv, 1);
        chk(g_bcvec === vv, "R6 bcast vector", g_bcvec, vv);
      end
    end
    do_reset();

    // R3 / R5: same class, strictly above in-service, acknowledge spurious
    trig(8'h55, 1'b0, 1'b0);
    ack_expect(8'h55, "R5 first");
    trig(8'h57, 1'b0, 1'b0);
    chk(core_irq === 1'b1, "R3 same class above", core_irq, 1);
    ack_expect(8'hFF, "R5 same class spurious");
    chk(g_irq_mid === 1'b0, "R5 irq low after ack", g_irq_mid, 0);
    chk(core_irq === 1'b1, "R5 irq re-evaluated", core_irq, 1);
    eoi();
    ack_expect(8'h57, "R5 after eoi");
    eoi();

    // R3: lower vector blocked by in-service, released by EOI
    trig(8'h50, 1'b0, 1'b0);
    ack_expect(8'h50, "R3 setup");
    trig(8'h40, 1'b0, 1'b0);
    chk(core_irq === 1'b0, "R3 blocked by svc", core_irq, 0);
    eoi();
    chk(core_irq === 1'b1, "R3 released", core_irq, 1);
    ack_expect(8'h40, "R3 ack released");
    eoi();

    // R3 / R9: task-priority masking and release
    set_tpr(8'h60);
    trig(8'h65, 1'b0, 1'b0);
    chk(core_irq === 1'b0, "R3 tpr mask", core_irq, 0);
    chk(proc_prio === 8'h60, "R4 ppr tpr", proc_prio, 8'h60);
    ack_expect(8'hFF, "R5 tpr spurious");
    set_tpr(8'h20);
    chk(core_irq === 1'b1, "R9 tpr lowered", core_irq, 1);
    ack_expect(8'h65, "R9 ack");
    eoi();
    set_tpr(8'h00);

    // R4 processor priority cases
    set_tpr(8'h3A);
    chk(proc_prio === 8'h3A, "R4 tpr only", proc_prio, 8'h3A);
    trig(8'h55, 1'b0, 1'b0);
    ack_expect(8'h55, "R4 setup");
    chk(proc_prio === 8'h50, "R4 svc wins", proc_prio, 8'h50);
    set_tpr(8'h5C);
    chk(proc_prio === 8'h5C, "R4 tpr above", proc_prio, 8'h5C);
    set_tpr(8'h50);
    chk(proc_prio === 8'h50, "R4 tpr equal class", proc_prio, 8'h50);
    set_tpr(8'h00);
    eoi();
    chk(proc_prio === 8'h00, "R4 cleared", proc_prio, 0);

    // R11 descending order
    trig(8'h30, 1'b0, 1'b0);
    trig(8'h80, 1'b0, 1'b0);
    trig(8'h61, 1'b0, 1'b0);
    ack_expect(8'h80, "R11 first");
    eoi();
    ack_expect(8'h61, "R11 second");
    eoi();
    ack_expect(8'h30, "R11 third");
    eoi();

    // R2 duplicate dropped keeps level mode
    trig(8'h44, 1'b1, 1'b0);
    trig(8'h44, 1'b0, 1'b0);
    ack_expect(8'h44, "R2 dup ack");
    ack_expect(8'hFF, "R2 single pending");
    eoi();
    chk(g_bcv === 1'b1, "R2 dup mode kept", g_bcv, 1);
    chk(g_bcvec === 8'h44, "R2 dup vector", g_bcvec, 8'h44);

    // R2 external delivery overwrites mode
    trig(8'h47, 1'b0, 1'b0);
    trig(8'h47, 1'b1, 1'b1);
    ack_expect(8'h47, "R2 ext ack");
    ack_expect(8'hFF, "R2 ext single");
    eoi();
    chk(g_bcv === 1'b1, "R2 ext mode level", g_bcv, 1);

    // R8 spurious configuration
    set_spur(10'h300);
    chk(spur_cfg === 10'h30F, "R8 bits 9:8", spur_cfg, 10'h30F);
    set_spur(10'h1A5);
    chk(spur_cfg === 10'h1AF, "R8 low nibble", spur_cfg, 10'h1AF);
    ack_expect(8'hAF, "R8 spurious vector");

    // R7 EOI aimed at spurious vector, and EOI with nothing in service
    set_spur(10'h09F);
    trig(8'h9F, 1'b1, 1'b0);
    ack_expect(8'h9F, "R7 setup");
    eoi();
    chk(g_bcv === 1'b0, "R7 no bcast", g_bcv, 0);
    chk(proc_prio === 8'h90, "R7 svc kept", proc_prio, 8'h90);
    set_spur(10'h0FF);
    eoi();
    chk(g_bcv === 1'b1, "R6 bcast after spur change", g_bcv, 1);
    chk(proc_prio === 8'h00, "R6 svc cleared", proc_prio, 0);
    eoi();
    chk(g_bcv === 1'b0, "R7 empty eoi", g_bcv, 0);
    chk(proc_prio === 8'h00, "R7 empty eoi ppr", proc_prio, 0);

    // R10 reset mid-flight
    trig(8'h70, 1'b1, 1'b0);
    do_reset();
    chk(core_irq === 1'b0, "R10 irq after reset", core_irq, 0);
    ack_expect(8'hFF, "R10 nothing pending");
    chk(spur_cfg === 10'h0FF, "R10 spur after reset", spur_cfg, 10'h0FF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule